// File: doc/BRIEF.md
# Buffer-to-Transmitter Word Feeder

This engine moves a packet, one 16-bit word at a time, from a word-addressed memory into a host-interface transmitter. Each time the transmitter asks for a word, it raises a one-cycle output request. The engine then works from a control block in memory whose base address it holds in a register. The control block carries a current-pointer and an end-pointer. The engine clears the transmitter's pending request, fetches the next word, hands it to the transmitter with a load strobe and stores the advanced pointer back.

The engine does not detect that the buffer is done when it sends the last word. It detects it on the request that follows, when the two pointers are equal. At that point it writes a completion status into the control block and merges an interrupt word from the control block into a pending-interrupt register. When the last word goes out with the throwaway flag set, the engine also issues a final-bit control function.

A separate set-control request loads the transmitter's control flops from the first word of the control block and then posts its own completion status. When both requests arrive together, set-control is served first.

Top module: `pkt_tx_engine`

## Requirements
- R1: After reset, irq_pending is zero, and tx_load, tx_reset, ctl_strobe and mem_en are all low.
- R2: Each output request gives exactly one tx_reset pulse. It comes before any memory access made for that request, and 3 cycles before the tx_load of that request when one follows.
- R3: The control block holds the current-pointer at base+4 and the end-pointer at base+5. If they differ, the engine loads the word at the current-pointer onto tx_data with one tx_load pulse. It then writes current-pointer+1 (modulo 2^16) to base+4.
- R4: If the end-pointer equals the current-pointer when a request is served, no word is sent and completion code 0x01FF is posted at base+10.
- R5: A post writes (code AND hw_status) to base+off. It then reads base+off+1 and ORs that word into irq_pending. Bits of irq_pending stay set until irq_clear is pulsed.
- R6: If the word sent is the last one (end − pointer − 1 = 0 in 16-bit unsigned arithmetic) and thr_mode is 1, ctl_func = 2 is driven with one ctl_strobe in the same cycle as tx_load. With thr_mode 0 there is no strobe.
- R7: A set-control request reads the word at base+0 and drives it on ctl_func with one ctl_strobe. It then posts 0x01FF at base+6.
- R8: When set-control and output requests are pending together, the set-control strobe comes before the output's tx_reset. Both requests are served.
- R9: cb_load replaces the control-block base, and every later access uses the new base.
- R10: Pointer arithmetic wraps at 16 bits. A buffer from 0xFFFF to 0x0000 sends one word, counts it as last, and leaves the pointer at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cb_load | input | 1 | Load control-block base |
| cb_wdata | input | 16 | New control-block base |
| wake_out | input | 1 | Transmitter word request (one-cycle pulse) |
| wake_ctl | input | 1 | Set-control request (one-cycle pulse) |
| thr_mode | input | 1 | Throwaway-mode flag from the transmitter |
| hw_status | input | 16 | Hardware status bits ANDed into posts |
| irq_clear | input | 1 | Clears irq_pending |
| mem_rdata | input | 16 | Memory read data, one cycle after the request |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| tx_data | output | 16 | Word for the transmitter |
| tx_load | output | 1 | Loads tx_data and starts the transmitter |
| tx_reset | output | 1 | Resets the transmitter, clearing its request |
| ctl_func | output | 16 | Control-function value |
| ctl_strobe | output | 1 | Applies ctl_func |
| irq_pending | output | 16 | Pending-interrupt bits |

## Verification
The hardest case to reach is two requests arriving in the same cycle. Set-control and output requests are raised together, and the bench timestamps the set-control strobe and the transmitter reset to show their order. The completion post is also awkward, because it appears only on an extra request after the last word has gone. The bench therefore runs each buffer one request past its end and checks that the post arrives then, and only then. It also checks that no data is loaded with that post.

// File: rtl/pkt_tx_engine.sv
module pkt_tx_engine #(
  parameter int W        = 16,
  parameter int OFF_CUR  = 4,
  parameter int OFF_END  = 5,
  parameter int OFF_OPST = 10,
  parameter int OFF_CPST = 6,
  parameter int DONE     = 'o777,
  parameter int LASTFN   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cb_load,
  input  logic [W-1:0] cb_wdata,
  input  logic         wake_out,
  input  logic         wake_ctl,
  input  logic         thr_mode,
  input  logic [W-1:0] hw_status,
  input  logic         irq_clear,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_en,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic [W-1:0] tx_data,
  output logic         tx_load,
  output logic         tx_reset,
  output logic [W-1:0] ctl_func,
  output logic         ctl_strobe,
  output logic [W-1:0] irq_pending
);

  typedef enum logic [3:0] {
    S_IDLE, S_O0, S_O1, S_O2, S_O3, S_C0, S_C1, S_P0, S_P1, S_P2
  } st_t;

  st_t          st;
  logic         pend_out, pend_ctl;
  logic [W-1:0] cb, ptr_q, end_q, code_q, off_q;
  logic         last_w;

  assign last_w = ((end_q - ptr_q - W'(1)) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      pend_out    <= 1'b0;
      pend_ctl    <= 1'b0;
      cb          <= '0;
      ptr_q       <= '0;
      end_q       <= '0;
      code_q      <= '0;
      off_q       <= '0;
      irq_pending <= '0;
    end else begin
      pend_out <= (pend_out && st != S_O0) || wake_out;
      pend_ctl <= (pend_ctl && st != S_C0) || wake_ctl;
      if (cb_load) cb <= cb_wdata;
      irq_pending <= (irq_clear ? '0 : irq_pending) | ((st == S_P2) ? mem_rdata : '0);
      case (st)
        S_IDLE: if (pend_ctl) st <= S_C0;
                else if (pend_out) st <= S_O0;
        S_O0:   st <= S_O1;
        S_O1: begin
          ptr_q <= mem_rdata;
          st    <= S_O2;
        end
        S_O2: begin
          end_q <= mem_rdata;
          if (mem_rdata == ptr_q) begin
            code_q <= W'(DONE);
            off_q  <= W'(OFF_OPST);
            st     <= S_P0;
          end else begin
            st <= S_O3;
          end
        end
        S_O3:   st <= S_IDLE;
        S_C0:   st <= S_C1;
        S_C1: begin
          code_q <= W'(DONE);
          off_q  <= W'(OFF_CPST);
          st     <= S_P0;
        end
        S_P0:   st <= S_P1;
        S_P1:   st <= S_P2;
        S_P2:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_wdata  = '0;
    tx_data    = '0;
    tx_load    = 1'b0;
    tx_reset   = 1'b0;
    ctl_func   = '0;
    ctl_strobe = 1'b0;
    case (st)
      S_O0: begin
        tx_reset = 1'b1;
        mem_en   = 1'b1;
        mem_addr = cb + W'(OFF_CUR);
      end
      S_O1: begin
        mem_en   = 1'b1;
        mem_addr = cb + W'(OFF_END);
      end
      S_O2: if (mem_rdata != ptr_q) begin
        mem_en   = 1'b1;
        mem_addr = ptr_q;
      end
      S_O3: begin
        tx_data   = mem_rdata;
        tx_load   = 1'b1;
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cb + W'(OFF_CUR);
        mem_wdata = ptr_q + W'(1);
        if (last_w && thr_mode) begin
          ctl_func   = W'(LASTFN);
          ctl_strobe = 1'b1;
        end
      end
      S_C0: begin
        mem_en   = 1'b1;
        mem_addr = cb;
      end
      S_C1: begin
        ctl_func   = mem_rdata;
        ctl_strobe = 1'b1;
      end
      S_P0: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cb + off_q;
        mem_wdata = code_q & hw_status;
      end
      S_P1: begin
        mem_en   = 1'b1;
        mem_addr = cb + off_q + W'(1);
      end
      default: ;
    endcase
  end

  assert_reset_before_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> $past(tx_reset, 3));

  assert_ptr_writeback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (mem_we && mem_addr == cb + W'(OFF_CUR)));

  assert_lastfn_with_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && ctl_strobe) |-> (ctl_func == W'(LASTFN)));

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_clear |=> (($past(irq_pending) & ~irq_pending) == '0));

  assert_one_action_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_reset, tx_load, (mem_we && !tx_load)}));

endmodule

// File: tb/tb_pkt_tx_engine.sv
module tb_pkt_tx_engine;
  logic        clk = 0, rst_n = 0;
  logic        cb_load = 0, wake_out = 0, wake_ctl = 0, thr_mode = 0, irq_clear = 0;
  logic [15:0] cb_wdata = 0, hw_status = 16'h0F3C, mem_rdata;
  logic        mem_en, mem_we, tx_load, tx_reset, ctl_strobe;
  logic [15:0] mem_addr, mem_wdata, tx_data, ctl_func, irq_pending;

  pkt_tx_engine dut (.*);

  always #4 clk = ~clk;

  logic [15:0] mem [0:255];
  always @(posedge clk) if (mem_en) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    else mem_rdata <= mem[mem_addr[7:0]];
  end

  int cyc = 0, n_load = 0, n_rst = 0, n_ctl = 0, t_rst = 0, t_ctl = 0;
  logic [15:0] last_tx, last_fn;
  logic        ctl_with_load;
  always @(negedge clk) begin
    cyc++;
    if (tx_load) begin n_load++; last_tx = tx_data; end
    if (tx_reset) begin n_rst++; t_rst = cyc; end
    if (ctl_strobe) begin n_ctl++; t_ctl = cyc; last_fn = ctl_func; ctl_with_load = tx_load; end
  end

  int checks = 0, fails = 0;
  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic clr_counts();
    n_load = 0; n_rst = 0; n_ctl = 0; ctl_with_load = 0;
  endtask

  task automatic pulse_out(); @(posedge clk); #2 wake_out = 1; @(posedge clk); #2 wake_out = 0; repeat (12) @(posedge clk); #2; endtask
  task automatic pulse_ctl(); @(posedge clk); #2 wake_ctl = 1; @(posedge clk); #2 wake_ctl = 0; repeat (12) @(posedge clk); #2; endtask

  task automatic t_reset();
    @(negedge clk);
    chk(irq_pending == 0, "R1 irq", irq_pending, 0);
    chk(!tx_load && !tx_reset && !ctl_strobe && !mem_en, "R1 strobes",
        {tx_load, tx_reset, ctl_strobe, mem_en}, 0);
  endtask

  task automatic t_setctl();
    mem[8'h20] = 16'h00A5; mem[8'h26] = 16'hDEAD; mem[8'h27] = 16'h0003;
    clr_counts();
    pulse_ctl();
    chk(n_ctl == 1 && last_fn == 16'h00A5, "R7 ctl value", last_fn, 16'h00A5);
    chk(mem[8'h26] == (16'h01FF & 16'h0F3C), "R7 post", mem[8'h26], 16'h013C);
    chk(irq_pending == 16'h0003, "R5 irq merge", irq_pending, 3);
  endtask

  task automatic t_send3();
    mem[8'h24] = 16'h0040; mem[8'h25] = 16'h0043;
    mem[8'h40] = 16'h1111; mem[8'h41] = 16'h2222; mem[8'h42] = 16'h3333;
    mem[8'h2A] = 16'hBEEF; mem[8'h2B] = 16'h0100;
    thr_mode = 0;
    clr_counts();
    pulse_out();
    chk(n_load == 1 && last_tx == 16'h1111, "R3 word0", last_tx, 16'h1111);
    chk(mem[8'h24] == 16'h0041, "R3 ptr", mem[8'h24], 16'h0041);
    chk(n_rst == 1, "R2 one reset", n_rst, 1);
    pulse_out(); pulse_out();
    chk(n_load == 3 && last_tx == 16'h3333, "R3 word2", last_tx, 16'h3333);
    chk(n_ctl == 0, "R6 no strobe thr=0", n_ctl, 0);
    chk(mem[8'h2A] == 16'hBEEF, "R4 no early post", mem[8'h2A], 16'hBEEF);
    pulse_out();
    chk(n_load == 3, "R4 no data on done", n_load, 3);
    chk(n_rst == 4, "R2 reset on done", n_rst, 4);
    chk(mem[8'h2A] == 16'h013C, "R4 post", mem[8'h2A], 16'h013C);
    chk(irq_pending == 16'h0103, "R5 irq or", irq_pending, 16'h0103);
  endtask

  task automatic t_thr_last();
    mem[8'h24] = 16'h0050; mem[8'h25] = 16'h0051; mem[8'h50] = 16'h5A5A;
    thr_mode = 1;
    clr_counts();
    pulse_out();
    chk(n_ctl == 1 && last_fn == 16'h0002 && ctl_with_load, "R6 final-bit fn", last_fn, 2);
    thr_mode = 0;
  endtask

  task automatic t_clear();
    @(posedge clk); #2 irq_clear = 1; @(posedge clk); #2 irq_clear = 0;
    @(negedge clk);
    chk(irq_pending == 0, "R5 clear", irq_pending, 0);
  endtask

  task automatic t_both();
    mem[8'h24] = 16'h0060; mem[8'h25] = 16'h0061; mem[8'h60] = 16'h7777;
    mem[8'h27] = 16'h0000;
    clr_counts();
    @(posedge clk); #2 wake_out = 1; wake_ctl = 1; @(posedge clk); #2 wake_out = 0; wake_ctl = 0;
    repeat (20) @(posedge clk); #2;
    chk(n_ctl == 1 && n_rst == 1 && n_load == 1, "R8 both served", n_load, 1);
    chk(t_ctl < t_rst, "R8 order", t_ctl, t_rst);
  endtask

  task automatic t_newbase_wrap();
    @(posedge clk); #2 cb_load = 1; cb_wdata = 16'h0080; @(posedge clk); #2 cb_load = 0;
    mem[8'h84] = 16'hFFFF; mem[8'h85] = 16'h0000; mem[8'hFF] = 16'hC0DE;
    mem[8'h24] = 16'h0061;
    thr_mode = 1;
    clr_counts();
    pulse_out();
    chk(last_tx == 16'hC0DE && n_load == 1, "R9 new base", last_tx, 16'hC0DE);
    chk(mem[8'h84] == 16'h0000, "R10 wrap ptr", mem[8'h84], 0);
    chk(n_ctl == 1 && last_fn == 2, "R10 wrap last", n_ctl, 1);
    chk(mem[8'h24] == 16'h0061, "R9 old base untouched", mem[8'h24], 16'h0061);
    thr_mode = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    cb_wdata = 16'h0020;
    repeat (3) @(posedge clk);
    #2 rst_n = 1; cb_load = 1; @(posedge clk); #2 cb_load = 0;
    t_reset();
    t_setctl();
    t_send3();
    t_thr_last();
    t_clear();
    t_both();
    t_newbase_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule